// File: doc/BRIEF.md
# E3 G.832 Overhead Byte Generator

This block produces three overhead octets for every outgoing E3 frame in the G.832 format: the maintenance/adaptation byte (MA), the network-operator byte (NR) and the trail-trace byte (TR). Software loads a sixteen-entry trail-trace table, a default MA value, a default NR value and a small control word through a simple write port.

At each frame-start strobe the block latches a fresh set of three bytes, and the framer datapath reads them for the frame that is starting. The two remote-indication bits of MA can be taken from software or from the local receiver's status. The NR byte can be handed over to an external data-link octet source. The TR byte walks through the trail-trace table one entry per frame, so the whole identifier is sent once every sixteen frames.

Top module: `e3_ovh_gen`

## Requirements
- R1: While `rst` is high at a clock edge, every register returns to its reset value. After that edge `outMa`=0x10, `outNr`=0x00 and `outTr`=0x80. The MA register resets to 0x10, the NR register to 0x00, trail-trace entry 0 to 0x80, entries 1 to 15 to 0x00, and the control word to 0.
- R2: A write with `cfgWrEn` high stores `cfgWrData` at `cfgAddr`. Addresses 0 to 15 select the trail-trace entries, 16 is the MA register, 17 is the NR register and 18 is the control word. In the control word, bit 0 selects the MA remote-bit source, bit 1 enables the data link and bit 2 routes the data link into NR. Any other address has no effect.
- R3: The MA byte carries FERF in bit 7, FEBE in bit 6, payload type in bits 5:3, the multiframe indicator in bits 2:1 and SSM in bit 0. When control bit 0 is 0, all eight bits of `outMa` are taken from the MA register.
- R4: When control bit 0 is 1, `outMa` bit 7 equals `rxDefect` sampled in the frame-start cycle, and bits 5:0 still come from the MA register.
- R5: When control bit 0 is 1, `outMa` bit 6 is 1 only if `rxBipErr` was high in some cycle after the previous frame start (or after reset), up to and including the current frame-start cycle. Otherwise it is 0.
- R6: `outNr` takes `dlOctet` from the frame-start cycle when control bits 1 and 2 are both 1. In every other case it takes the NR register.
- R7: `outTr` takes the trail-trace entry at the current index. After reset the index is 0. Each frame start advances it by one, and it wraps from 15 back to 0, so entry 0 goes out in the first frame of each set of sixteen.
- R8: The outputs change only at a clock edge where `frameStart` is high. A register write in the same cycle as a frame start is not seen until the next frame start.
- R9: A synchronous reset in the middle of a sequence returns the index to 0. The next frame then sends trail-trace entry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfgWrEn | input | 1 | Register write strobe |
| cfgAddr | input | 5 | Register write address |
| cfgWrData | input | 8 | Register write data |
| frameStart | input | 1 | One-cycle pulse at the start of each outgoing frame |
| rxDefect | input | 1 | Receive-side defect, the source of the remote FERF bit |
| rxBipErr | input | 1 | Receive-side BIP error pulse, the source of the remote FEBE bit |
| dlOctet | input | 8 | Data-link octet offered for the NR byte |
| outMa | output | 8 | MA overhead byte for the current frame |
| outNr | output | 8 | NR overhead byte for the current frame |
| outTr | output | 8 | TR overhead byte for the current frame |

## Verification
The bench runs the trail-trace index past its wrap point and resets it mid-sequence. A design with an off-by-one counter would send the wrong entry first, or would skip entry 0 after the reset. It writes the MA register in the same cycle as a frame start, and puts a BIP error exactly in a frame-start cycle. An eager design would leak the new MA value into the current frame, and a careless error flag would drop or double-count that error. It also sets the data-link enable and the NR routing bit one at a time. A design that substitutes the data link on only one of them would send `dlOctet` in place of the NR register.

// File: rtl/e3_ovh_pkg.sv
package e3_ovh_pkg;
  localparam logic [7:0] MA_RST  = 8'h10;
  localparam logic [7:0] NR_RST  = 8'h00;
  localparam logic [7:0] TT0_RST = 8'h80;

  // strobes from control to datapath
  typedef struct packed {
    logic ttWr;
    logic maWr;
    logic nrWr;
    logic ctlWr;
    logic load;
  } ovhStrobe_t;
endpackage

// File: rtl/e3_ovh_ctrl.sv
module e3_ovh_ctrl
  import e3_ovh_pkg::*;
#(
  parameter int TT_LEN = 16,
  parameter int ADDR_W = 5,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfgWrEn,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic              frameStart,
  input  logic              rxDefect,
  input  logic              rxBipErr,
  output ovhStrobe_t        strb,
  output logic [IDX_W-1:0]  sendIdx,
  output logic              ferfRx,
  output logic              febeRx
);
  localparam int MA_ADDR  = TT_LEN;
  localparam int NR_ADDR  = TT_LEN + 1;
  localparam int CTL_ADDR = TT_LEN + 2;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(TT_LEN - 1);

  logic bipSeen;

  always_comb begin
    strb.ttWr  = cfgWrEn && (cfgAddr < ADDR_W'(TT_LEN));
    strb.maWr  = cfgWrEn && (cfgAddr == ADDR_W'(MA_ADDR));
    strb.nrWr  = cfgWrEn && (cfgAddr == ADDR_W'(NR_ADDR));
    strb.ctlWr = cfgWrEn && (cfgAddr == ADDR_W'(CTL_ADDR));
    strb.load  = frameStart;
  end

  always_ff @(posedge clk) begin
    if (rst)
      sendIdx <= '0;
    else if (frameStart)
      sendIdx <= (sendIdx == LAST_IDX) ? '0 : sendIdx + 1'b1;
  end

  // error seen since the last frame start
  always_ff @(posedge clk) begin
    if (rst)
      bipSeen <= 1'b0;
    else if (frameStart)
      bipSeen <= 1'b0;
    else if (rxBipErr)
      bipSeen <= 1'b1;
  end

  assign febeRx = bipSeen | rxBipErr;
  assign ferfRx = rxDefect;

  AST_IDX_WRAP: assert property (@(posedge clk) disable iff (rst)
    frameStart && sendIdx == LAST_IDX |=> sendIdx == '0); // R7
  AST_IDX_STEP: assert property (@(posedge clk) disable iff (rst)
    frameStart && sendIdx != LAST_IDX |=> sendIdx == $past(sendIdx) + 1'b1); // R7
  AST_IDX_HOLD: assert property (@(posedge clk) disable iff (rst)
    !frameStart |=> $stable(sendIdx)); // R8
  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strb.ttWr, strb.maWr, strb.nrWr, strb.ctlWr})); // R2
endmodule

// File: rtl/e3_ovh_dp.sv
module e3_ovh_dp
  import e3_ovh_pkg::*;
#(
  parameter int TT_LEN = 16,
  parameter int IDX_W  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  ovhStrobe_t       strb,
  input  logic [IDX_W-1:0] wrIdx,
  input  logic [7:0]       cfgWrData,
  input  logic [IDX_W-1:0] sendIdx,
  input  logic             ferfRx,
  input  logic             febeRx,
  input  logic [7:0]       dlOctet,
  output logic [7:0]       outMa,
  output logic [7:0]       outNr,
  output logic [7:0]       outTr
);
  logic [7:0] ttTab [TT_LEN];
  logic [7:0] maReg;
  logic [7:0] nrReg;
  logic [2:0] ctlReg;
  logic       maFromRx;
  logic       dlInNr;

  for (genvar g = 0; g < TT_LEN; g++) begin : gTt
    localparam logic [7:0] RST_VAL = (g == 0) ? TT0_RST : 8'h00;
    always_ff @(posedge clk) begin
      if (rst)
        ttTab[g] <= RST_VAL;
      else if (strb.ttWr && wrIdx == IDX_W'(g))
        ttTab[g] <= cfgWrData;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      maReg  <= MA_RST;
      nrReg  <= NR_RST;
      ctlReg <= '0;
    end else begin
      if (strb.maWr)  maReg  <= cfgWrData;
      if (strb.nrWr)  nrReg  <= cfgWrData;
      if (strb.ctlWr) ctlReg <= cfgWrData[2:0];
    end
  end

  assign maFromRx = ctlReg[0];
  assign dlInNr   = ctlReg[1] & ctlReg[2];

  always_ff @(posedge clk) begin
    if (rst) begin
      outMa <= MA_RST;
      outNr <= NR_RST;
      outTr <= TT0_RST;
    end else if (strb.load) begin
      outMa <= maFromRx ? {ferfRx, febeRx, maReg[5:0]} : maReg;
      outNr <= dlInNr ? dlOctet : nrReg;
      outTr <= ttTab[sendIdx];
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !strb.load |=> $stable(outMa) && $stable(outNr) && $stable(outTr)); // R8
  AST_MA_SW: assert property (@(posedge clk) disable iff (rst)
    strb.load && !maFromRx |=> outMa == $past(maReg)); // R3
  AST_FERF_RX: assert property (@(posedge clk) disable iff (rst)
    strb.load && maFromRx |=> outMa[7] == $past(ferfRx)); // R4
  AST_FEBE_RX: assert property (@(posedge clk) disable iff (rst)
    strb.load && maFromRx && febeRx |=> outMa[6]); // R5
  AST_NR_DL: assert property (@(posedge clk) disable iff (rst)
    strb.load && dlInNr |=> outNr == $past(dlOctet)); // R6
endmodule

// File: rtl/e3_ovh_gen.sv
module e3_ovh_gen
  import e3_ovh_pkg::*;
#(
  parameter int TT_LEN = 16,
  localparam int ADDR_W = $clog2(TT_LEN + 3),
  localparam int IDX_W  = $clog2(TT_LEN)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfgWrEn,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [7:0]        cfgWrData,
  input  logic              frameStart,
  input  logic              rxDefect,
  input  logic              rxBipErr,
  input  logic [7:0]        dlOctet,
  output logic [7:0]        outMa,
  output logic [7:0]        outNr,
  output logic [7:0]        outTr
);
  ovhStrobe_t       strb;
  logic [IDX_W-1:0] sendIdx;
  logic             ferfRx;
  logic             febeRx;

  e3_ovh_ctrl #(.TT_LEN(TT_LEN), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) uCtrl (
    .clk(clk), .rst(rst), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .frameStart(frameStart), .rxDefect(rxDefect), .rxBipErr(rxBipErr),
    .strb(strb), .sendIdx(sendIdx), .ferfRx(ferfRx), .febeRx(febeRx)
  );

  e3_ovh_dp #(.TT_LEN(TT_LEN), .IDX_W(IDX_W)) uDp (
    .clk(clk), .rst(rst), .strb(strb), .wrIdx(cfgAddr[IDX_W-1:0]),
    .cfgWrData(cfgWrData), .sendIdx(sendIdx), .ferfRx(ferfRx),
    .febeRx(febeRx), .dlOctet(dlOctet),
    .outMa(outMa), .outNr(outNr), .outTr(outTr)
  );
endmodule

// File: tb/sim_e3_ovh_gen.sv
`timescale 1ns/1ps
module sim_e3_ovh_gen;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfgWrEn = 1'b0;
  logic [4:0] cfgAddr = '0;
  logic [7:0] cfgWrData = '0;
  logic       frameStart = 1'b0;
  logic       rxDefect = 1'b0;
  logic       rxBipErr = 1'b0;
  logic [7:0] dlOctet = '0;
  logic [7:0] outMa, outNr, outTr;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // behavioural reference state
  byte unsigned mTt[16];
  byte unsigned mMa, mNr, eMa, eNr, eTr;
  int  mCtl, mIdx;
  bit  mBip;

  always #2 clk = ~clk;

  e3_ovh_gen u0 (
    .clk(clk), .rst(rst), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgWrData(cfgWrData), .frameStart(frameStart), .rxDefect(rxDefect),
    .rxBipErr(rxBipErr), .dlOctet(dlOctet),
    .outMa(outMa), .outNr(outNr), .outTr(outTr)
  );

  task automatic cmp(input string tag, input string what, input byte unsigned act, input byte unsigned exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%02h expected=%02h", tag, what, act, exp);
    end
  endtask

  // drive one cycle, advance the model, compare after the edge
  task automatic step(input bit r, input bit we, input int a, input byte unsigned d,
                      input bit fs, input bit def, input bit bip, input byte unsigned dl,
                      input string tag);
    rst = r; cfgWrEn = we; cfgAddr = 5'(a); cfgWrData = d;
    frameStart = fs; rxDefect = def; rxBipErr = bip; dlOctet = dl;
    if (r) begin
      for (int i = 0; i < 16; i++) mTt[i] = 8'h00;
      mTt[0] = 8'h80; mMa = 8'h10; mNr = 8'h00; mCtl = 0; mIdx = 0; mBip = 0;
      eMa = 8'h10; eNr = 8'h00; eTr = 8'h80;
    end else begin
      if (fs) begin
        if (mCtl % 2 == 1)
          eMa = {def, (mBip | bip), mMa[5:0]};
        else
          eMa = mMa;
        eNr = ((mCtl & 6) == 6) ? dl : mNr;
        eTr = mTt[mIdx];
        mIdx = (mIdx + 1) % 16;
        mBip = 0;
      end else if (bip) begin
        mBip = 1;
      end
      if (we) begin
        if (a < 16) mTt[a] = d;
        else if (a == 16) mMa = d;
        else if (a == 17) mNr = d;
        else if (a == 18) mCtl = d % 8;
      end
    end
    @(posedge clk);
    @(negedge clk);
    cmp(tag, "outMa", outMa, eMa);
    cmp(tag, "outNr", outNr, eNr);
    cmp(tag, "outTr", outTr, eTr);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, 8'hEE, tag);
  endtask

  task automatic wr(input int a, input byte unsigned d, input string tag);
    step(0, 1, a, d, 0, 0, 0, 8'hEE, tag);
  endtask

  task automatic frame(input bit def, input byte unsigned dl, input string tag);
    idle(2, tag);
    step(0, 0, 0, 0, 1, def, 0, dl, tag);
  endtask

  initial begin
    @(negedge clk);
    step(1, 0, 0, 0, 0, 0, 0, 0, "R1");
    step(1, 1, 16, 8'hFF, 1, 1, 1, 8'h77, "R1");
    idle(3, "R1");

    // default table: 0x80 then zeros, across a wrap
    for (int f = 0; f < 18; f++) frame(0, 8'h11, "R7");

    // load the table and defaults
    for (int i = 0; i < 16; i++) wr(i, byte'(i * 17 + 3), "R2");
    wr(16, 8'hA5, "R2");
    wr(17, 8'h3C, "R2");
    wr(25, 8'hFF, "R2");
    for (int f = 0; f < 17; f++) frame(1, 8'h22, "R3");

    // write colliding with frame start
    step(0, 1, 16, 8'h5A, 1, 0, 0, 8'h00, "R8");
    idle(3, "R8");
    wr(17, 8'h99, "R8");
    idle(2, "R8");
    frame(0, 8'h00, "R8");

    // remote bits from receive side
    wr(18, 8'h01, "R4");
    frame(1, 8'h00, "R4");
    frame(0, 8'h00, "R4");
    step(0, 0, 0, 0, 0, 0, 1, 8'h00, "R5");
    frame(0, 8'h00, "R5");
    frame(0, 8'h00, "R5");
    step(0, 0, 0, 0, 1, 1, 1, 8'h00, "R5");
    frame(0, 8'h00, "R5");

    // data link routing
    wr(18, 8'h02, "R6");
    frame(0, 8'hC3, "R6");
    wr(18, 8'h04, "R6");
    frame(0, 8'hC4, "R6");
    wr(18, 8'h06, "R6");
    frame(0, 8'hC5, "R6");
    frame(0, 8'hC6, "R6");
    wr(18, 8'h00, "R6");
    frame(0, 8'hC7, "R6");

    // reset mid sequence
    frame(0, 8'h00, "R9");
    frame(0, 8'h00, "R9");
    step(1, 0, 0, 0, 0, 0, 0, 0, "R9");
    for (int f = 0; f < 3; f++) frame(0, 8'h00, "R9");
    wr(0, 8'h4D, "R9");
    step(1, 0, 0, 0, 0, 0, 0, 0, "R9");
    frame(0, 8'h00, "R9");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule